// File: doc/BRIEF.md
# Doorbell Write-Match Test Register Bank

A byte-wide register target used to exercise doorbell writes from a host. It sits behind a memory window and an I/O window; a flag on each access says which window it came through. Writing a mode number to address 0 picks one of six test slots (two windows by three match modes). Each slot publishes a read-only little-endian header that describes the doorbell address and match value. The header also holds a live hit counter and a zero-terminated name.

Software selects a slot, reads the header to learn where the doorbell is, and writes to it. The block counts each write that passes the slot's match rules. In the two notifying modes it also raises a sticky notify flag, which clears when the slot is read or when a new selection is made. Reads return data one cycle after the request, together with a valid strobe.

Top module: `dbell_bank`

## Requirements
- R1: A write to address 0 first deselects any slot and clears the notify flag. If the written value v is below 3, slot io_win_i*3+v then becomes active and its count is zeroed. A value of 3 or more leaves no slot active.
- R2: The header of the active slot reads as follows, little-endian: byte 0 is the slot index; byte 1 is 1; bytes 2, 3 and 9 to 11 are 0; bytes 4 to 7 are the doorbell offset; byte 8 is the match value; bytes 12 to 15 are the 32-bit hit count.
- R3: The doorbell offset is 2048 plus the slot index for memory slots (0 to 2) and 128 plus the slot index for I/O slots (3 to 5). The match value is 0xFA for data-match slots (mode 2) and 0xCE for all other slots.
- R4: From byte 16 the header holds the ASCII name, followed by a zero byte. The name is a window prefix ("mmio-" or "portio-") followed by a mode suffix: "no-eventfd" for mode 0, "wildcard-eventfd" for mode 1, "datamatch-eventfd" for mode 2.
- R5: A read returns 0 when no slot is active. It also returns 0 when address plus access size is at or above the header length, which is 17 plus the name length.
- R6: A write to a nonzero address adds 1 (mod 2^32) to the count only when a slot is active and the address equals its doorbell offset. The window flag of that write plays no part.
- R7: In data-match mode a doorbell write is also dropped when its access size is not 1 or its data is not 0xFA. Modes 0 and 1 accept any size and any data.
- R8: A counted hit in mode 1 or 2 sets notify_o, and it stays set until a read while a slot is active or a write to address 0. In mode 0, notify_o stays low.
- R9: Every read request gives exactly one rvalid_o pulse, with rdata_o, on the cycle after the request.
- R10: Reset leaves no slot active, with notify_o and rvalid_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write request |
| rd_i | input | 1 | Read request |
| io_win_i | input | 1 | Access arrived on the I/O window (1) or the memory window (0) |
| addr_i | input | ADDR_W | Byte address within the window |
| size_i | input | 3 | Access size in bytes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data strobe, one cycle after rd_i |
| notify_o | output | 1 | Sticky notify flag |

## Verification
Every slot's full header is read byte by byte, including past its end with one-byte and two-byte sizes. This separates the layout, the offset and match rules, the name builder and the length bound. Doorbell writes are tried at the right address and at an adjacent wrong one, with matching and non-matching data, and with one-byte and two-byte sizes. This sets data-match slots apart from wildcard and plain slots. Selecting a slot, deselecting it with an out-of-range value, reselecting it and resetting it show that the count and notify flag are cleared by each of these. Writes arriving through the other window show that the window flag only steers selection.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned N_MODE  = 3;
  localparam int unsigned HDR_FIX = 16;
  localparam int unsigned CNT_W   = 32;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_ANY   = 2'd1,
    MODE_DATA  = 2'd2
  } mode_e;

  localparam logic [7:0] MATCH_DATA = 8'hFA;
  localparam logic [7:0] MATCH_NONE = 8'hCE;

  function automatic mode_e slot_mode(input logic [2:0] slot);
    return (slot >= 3'd3) ? mode_e'(2'(slot - 3'd3)) : mode_e'(slot[1:0]);
  endfunction

  function automatic int name_len(input logic [2:0] slot);
    int p, s;
    p = (slot >= 3'd3) ? 7 : 5;
    case (slot_mode(slot))
      MODE_PLAIN: s = 10;
      MODE_ANY:   s = 16;
      default:    s = 17;
    endcase
    return p + s;
  endfunction

  // character idx of the slot name, 0 past the end
  function automatic logic [7:0] name_chr(input logic [2:0] slot, input int idx);
    logic [8*5-1:0]  pre_m;
    logic [8*7-1:0]  pre_p;
    logic [8*10-1:0] suf0;
    logic [8*16-1:0] suf1;
    logic [8*17-1:0] suf2;
    int plen, j;
    pre_m = "mmio-";
    pre_p = "portio-";
    suf0  = "no-eventfd";
    suf1  = "wildcard-eventfd";
    suf2  = "datamatch-eventfd";
    plen  = (slot >= 3'd3) ? 7 : 5;
    if (idx < 0) return 8'h00;
    if (idx < plen)
      return (slot >= 3'd3) ? pre_p[8*(6-idx) +: 8] : pre_m[8*(4-idx) +: 8];
    j = idx - plen;
    case (slot_mode(slot))
      MODE_PLAIN: return (j < 10) ? suf0[8*(9-j)  +: 8] : 8'h00;
      MODE_ANY:   return (j < 16) ? suf1[8*(15-j) +: 8] : 8'h00;
      default:    return (j < 17) ? suf2[8*(16-j) +: 8] : 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dbell_sel.sv
module dbell_sel
  import dbell_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_wr_i,
  input  logic [7:0]       sel_val_i,
  input  logic             io_win_i,
  input  logic             hit_i,
  input  logic             rd_i,
  output logic             act_o,
  output logic [2:0]       slot_o,
  output mode_e            mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ntf_o
);
  logic             act_q, ntf_q;
  logic [2:0]       slot_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       slot_d;

  assign slot_d = (io_win_i ? 3'd3 : 3'd0) + {1'b0, sel_val_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ntf_q  <= 1'b0;
      slot_q <= '0;
      cnt_q  <= '0;
    end else if (sel_wr_i) begin
      act_q <= 1'b0;
      ntf_q <= 1'b0;
      if (sel_val_i < 8'(N_MODE)) begin
        act_q  <= 1'b1;
        slot_q <= slot_d;
        cnt_q  <= '0;
      end
    end else if (hit_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (slot_mode(slot_q) != MODE_PLAIN) ntf_q <= 1'b1;
    end else if (rd_i && act_q) begin
      ntf_q <= 1'b0;
    end
  end

  assign act_o  = act_q;
  assign slot_o = slot_q;
  assign mode_o = slot_mode(slot_q);
  assign cnt_o  = cnt_q;
  assign ntf_o  = ntf_q;

  assert_sel_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && sel_val_i < 8'd3) |=> (act_q && cnt_q == '0 && !ntf_q));
  assert_sel_none_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && sel_val_i >= 8'd3) |=> !act_q);
  assert_cnt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_wr_i && !hit_i) |=> $stable(cnt_q));
  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_wr_i && hit_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_plain_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && slot_mode(slot_q) == MODE_PLAIN) |-> !ntf_q);
  assert_ntf_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ntf_q) |-> $past(hit_i));
endmodule

// File: rtl/dbell_match.sv
module dbell_match
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned MEM_WIN = 2048,
  parameter int unsigned IO_WIN  = 128
) (
  input  logic              act_i,
  input  logic [2:0]        slot_i,
  input  mode_e             mode_i,
  input  logic              db_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [7:0]        wdata_i,
  output logic [ADDR_W-1:0] door_o,
  output logic              hit_o
);
  logic data_ok;

  assign door_o  = ADDR_W'((slot_i >= 3'd3) ? IO_WIN : MEM_WIN) + ADDR_W'(slot_i);
  assign data_ok = (mode_i != MODE_DATA) || (size_i == 3'd1 && wdata_i == MATCH_DATA);
  assign hit_o   = db_wr_i && act_i && (addr_i == door_o) && data_ok;
endmodule

// File: rtl/dbell_hdr.sv
module dbell_hdr
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              act_i,
  input  logic [2:0]        slot_i,
  input  mode_e             mode_i,
  input  logic [ADDR_W-1:0] door_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  output logic [7:0]        byte_o
);
  logic [31:0] off32;
  logic [7:0]  fld;
  int          hlen;
  logic        oob;

  assign off32 = 32'(door_i);
  assign hlen  = int'(HDR_FIX) + name_len(slot_i) + 1;
  assign oob   = (int'(addr_i) + int'(size_i)) >= hlen;

  always_comb begin
    fld = 8'h00;
    if (addr_i < ADDR_W'(HDR_FIX)) begin
      case (addr_i[3:0])
        4'd0:  fld = {5'd0, slot_i};
        4'd1:  fld = 8'd1;
        4'd4:  fld = off32[7:0];
        4'd5:  fld = off32[15:8];
        4'd6:  fld = off32[23:16];
        4'd7:  fld = off32[31:24];
        4'd8:  fld = (mode_i == MODE_DATA) ? MATCH_DATA : MATCH_NONE;
        4'd12: fld = cnt_i[7:0];
        4'd13: fld = cnt_i[15:8];
        4'd14: fld = cnt_i[23:16];
        4'd15: fld = cnt_i[31:24];
        default: fld = 8'h00;
      endcase
    end else begin
      fld = name_chr(slot_i, int'(addr_i) - int'(HDR_FIX));
    end
  end

  assign byte_o = (!act_i || oob) ? 8'h00 : fld;
endmodule

// File: rtl/dbell_bank.sv
module dbell_bank
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned MEM_WIN = 2048,
  parameter int unsigned IO_WIN  = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              io_win_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              notify_o
);
  logic              sel_wr, db_wr, act, hit;
  logic [2:0]        slot;
  mode_e             mode;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] door;
  logic [7:0]        rd_byte;
  logic [7:0]        rdata_q;
  logic              rvalid_q;

  assign sel_wr = wr_i && (addr_i == '0);
  assign db_wr  = wr_i && (addr_i != '0);

  dbell_sel u_sel (
    .clk_i, .rst_ni,
    .sel_wr_i (sel_wr),
    .sel_val_i(wdata_i),
    .io_win_i,
    .hit_i    (hit),
    .rd_i,
    .act_o    (act),
    .slot_o   (slot),
    .mode_o   (mode),
    .cnt_o    (cnt),
    .ntf_o    (notify_o)
  );

  dbell_match #(.ADDR_W(ADDR_W), .MEM_WIN(MEM_WIN), .IO_WIN(IO_WIN)) u_match (
    .act_i  (act),
    .slot_i (slot),
    .mode_i (mode),
    .db_wr_i(db_wr),
    .addr_i,
    .size_i,
    .wdata_i,
    .door_o (door),
    .hit_o  (hit)
  );

  dbell_hdr #(.ADDR_W(ADDR_W)) u_hdr (
    .act_i (act),
    .slot_i(slot),
    .mode_i(mode),
    .door_i(door),
    .cnt_i (cnt),
    .addr_i,
    .size_i,
    .byte_o(rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rd_byte;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  assert_rd_lat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  assert_rd_none_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  assert_idle_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !act) |=> rdata_o == 8'h00);
  assert_data_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && mode == MODE_DATA) |-> (size_i == 3'd1 && wdata_i == MATCH_DATA));
endmodule

// File: tb/tb_dbell_bank.sv
`timescale 1ns/1ps
module tb_dbell_bank;
  localparam real CLK_P = 5.0;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0, io_win_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [2:0]  size_i = 3'd1;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        rvalid_o, notify_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #(CLK_P/2) clk_i = ~clk_i;

  dbell_bank dut (.*);

  function automatic string slot_name(int s);
    string p, m;
    p = (s >= 3) ? "portio-" : "mmio-";
    case (s % 3)
      0: m = "no-eventfd";
      1: m = "wildcard-eventfd";
      default: m = "datamatch-eventfd";
    endcase
    return {p, m};
  endfunction

  function automatic logic [7:0] exp_hdr(int s, int a, int unsigned cnt, int sz);
    string nm;
    int hl, off;
    nm  = slot_name(s);
    hl  = 17 + nm.len();
    off = ((s >= 3) ? 128 : 2048) + s;
    if (a + sz >= hl) return 8'h00;
    if (a >= 16) return (a - 16 < nm.len()) ? nm[a-16] : 8'h00;
    case (a)
      0: return 8'(s);
      1: return 8'd1;
      4: return off[7:0];
      5: return off[15:8];
      6: return off[23:16];
      7: return off[31:24];
      8: return (s % 3 == 2) ? 8'hFA : 8'hCE;
      12: return cnt[7:0];
      13: return cnt[15:8];
      14: return cnt[23:16];
      15: return cnt[31:24];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(bit io, int a, int d, int sz);
    @(negedge clk_i);
    wr_i = 1'b1; io_win_i = io; addr_i = 12'(a); wdata_i = 8'(d); size_i = 3'(sz);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_rd(int a, int sz, logic [7:0] exp, string tag);
    item_t it;
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = 12'(a); size_i = 3'(sz);
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic rd_cnt(int s, int unsigned cnt, string tag);
    for (int b = 12; b < 16; b++) do_rd(b, 1, exp_hdr(s, b, cnt, 1), tag);
  endtask

  task automatic sel(int s);
    do_wr(s >= 3, 0, s % 3, 1);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rvalid_o) begin
        if (sb_q.size() == 0) begin
          chk("R9 unexpected rvalid", 32'(rvalid_o), 32'd0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          chk(it.tag, 32'(rdata_o), 32'(it.exp));
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset notify", 32'(notify_o), 32'd0);
    chk("R10 reset rvalid", 32'(rvalid_o), 32'd0);
    rst_ni = 1'b1;
    do_rd(0, 1, 8'h00, "R5 idle read");
    do_rd(12, 1, 8'h00, "R10 no slot after reset");

    // full header of every slot, R2 R3 R4 R5
    for (int s = 0; s < 6; s++) begin
      int hl;
      hl = 17 + slot_name(s).len();
      sel(s);
      for (int a = 0; a < hl + 2; a++) do_rd(a, 1, exp_hdr(s, a, 0, 1), "R2 R3 R4 header byte");
      do_rd(hl - 2, 2, 8'h00, "R5 size 2 bound");
      do_rd(hl - 3, 2, exp_hdr(s, hl - 3, 0, 2), "R5 size 2 inside");
    end

    // wildcard memory slot 1, door 2049
    sel(1);
    do_wr(0, 2048, 8'h11, 1);
    chk("R6 wrong offset notify", 32'(notify_o), 32'd0);
    rd_cnt(1, 0, "R6 wrong offset count");
    do_wr(0, 2049, 8'h55, 2);
    chk("R8 wildcard hit notify", 32'(notify_o), 32'd1);
    do_wr(0, 2049, 8'h00, 1);
    chk("R8 notify sticky", 32'(notify_o), 32'd1);
    do_rd(12, 1, 8'd2, "R6 wildcard count");
    chk("R8 read clears notify", 32'(notify_o), 32'd0);
    do_wr(1, 2049, 8'h77, 4);
    rd_cnt(1, 3, "R6 other window hit");

    // data-match memory slot 2, door 2050
    sel(2);
    do_wr(0, 2050, 8'hCE, 1);
    do_wr(0, 2050, 8'hFA, 2);
    chk("R7 rejected notify", 32'(notify_o), 32'd0);
    rd_cnt(2, 0, "R7 wrong value or size");
    do_wr(0, 2050, 8'hFA, 1);
    chk("R8 datamatch notify", 32'(notify_o), 32'd1);
    do_wr(0, 0, 7, 1);
    chk("R8 select clears notify", 32'(notify_o), 32'd0);
    do_rd(12, 1, 8'h00, "R1 value 3+ deselects");
    do_wr(0, 2050, 8'hFA, 1);
    chk("R6 no slot no notify", 32'(notify_o), 32'd0);
    sel(2);
    rd_cnt(2, 0, "R1 reselect clears count");

    // plain memory slot 0
    sel(0);
    do_wr(0, 2048, 8'h3C, 2);
    chk("R8 plain no notify", 32'(notify_o), 32'd0);
    rd_cnt(0, 1, "R6 plain count");

    // I/O data-match slot 5, door 133
    sel(5);
    do_wr(0, 133, 8'hFA, 1);
    do_wr(1, 132, 8'hFA, 1);
    rd_cnt(5, 1, "R6 R7 io datamatch");

    // I/O wildcard slot 4 then reset
    sel(4);
    for (int k = 0; k < 5; k++) do_wr(1, 132, k, 1);
    rd_cnt(4, 5, "R6 io wildcard count");
    do_wr(1, 132, 8'h01, 1);
    chk("R8 io notify", 32'(notify_o), 32'd1);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 reset clears notify", 32'(notify_o), 32'd0);
    rst_ni = 1'b1;
    do_rd(0, 1, 8'h00, "R10 reset deselects");

    repeat (4) @(negedge clk_i);
    chk("R9 all reads answered", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule